// File: doc/BRIEF.md
# Nested Interrupt Acknowledge Controller

This block sits next to a processor's instruction sequencer and decides, each time an instruction completes, whether a pending interrupt may be taken. It handles requests while another interrupt is already being serviced. The processor signals each completed instruction with a boundary strobe. The block answers with a one-cycle acknowledge pulse that carries the index of the source it took. It also drives the interrupt-enable flag (IE) and the in-service-priority flag (ISP) that the processor keeps in its status word.

Maskable sources are latched into a pending set. Each one has a mask bit and a one-bit priority flag (0 = high, 1 = low). A non-maskable line and a software-interrupt strobe are latched as well. Every acknowledge pushes a context frame (IE, ISP, kind of service) onto a small stack. A return pops the frame again, so the rules for nesting follow the routine that is currently running.

A request that is refused stays pending. It becomes eligible again once the return has completed and one instruction of the interrupted code has run.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, IE=0, ISP=1, ack=0, nothing is in service and the context stack is empty.
- R2: Decisions are made only on a cycle with `boundary`=1. The acknowledge is a pulse of exactly one cycle, in the cycle after that boundary. `ack_idx` encodes maskable source i as i, the software interrupt as N and the non-maskable request as N+1.
- R3: Any acknowledge clears IE. `ei` sets IE and `di` clears it. If an acknowledge and `ei` occur in the same cycle, the acknowledge wins.
- R4: While a non-maskable interrupt is in service, no request is accepted: not a second non-maskable request, not a software interrupt, not a maskable request.
- R5: A non-maskable request is accepted whenever no non-maskable service is active, whatever the value of IE. It outranks a software interrupt, and a software interrupt outranks every maskable request.
- R6: A maskable request is eligible only when IE=1 and its mask bit is 0. While ISP=0, only sources whose priority flag is 0 are eligible.
- R7: Among eligible maskable sources, a source with priority flag 0 beats one with flag 1. Among sources of the same priority, the lowest index wins.
- R8: After a maskable acknowledge, ISP equals the taken source's priority flag. After a software or non-maskable acknowledge, ISP=1.
- R9: A return restores the IE, ISP and service kind that were saved by the matching acknowledge. A return with an empty stack changes nothing.
- R10: The boundary that coincides with a return never acknowledges. If the return arrives without a boundary, the next boundary is the one that does not acknowledge. The boundary after that may take a held request.
- R11: When the stack holds STACK_DEPTH frames, no acknowledge is made and all requests stay pending.
- R12: Request inputs are latched. A request stays pending until it is acknowledged, including while its mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_SRC | Maskable request pulses, one per source |
| irq_mask | input | NUM_SRC | Per-source mask, 1 = masked |
| irq_low | input | NUM_SRC | Per-source priority flag, 1 = low priority |
| nmi_req | input | 1 | Non-maskable request pulse |
| swi_req | input | 1 | Software-interrupt instruction strobe |
| ei | input | 1 | Set IE |
| di | input | 1 | Clear IE |
| reti | input | 1 | Return-from-interrupt strobe |
| boundary | input | 1 | Instruction-boundary strobe |
| ack | output | 1 | One-cycle acknowledge pulse |
| ack_idx | output | IDX_W | Index of the source taken |
| ie | output | 1 | Interrupt-enable flag |
| isp | output | 1 | In-service-priority flag |

## Verification
A wrong in-service kind or ISP value does not show immediately. It appears at the first boundary after it, as an acknowledge that should have been refused, or as a refusal where an acknowledge was due. A corrupted stack frame shows at the return, because IE and ISP then come back with the wrong values one cycle after `reti`. Errors in the pending latches or the arbitration show in the pulse one cycle after the deciding boundary, either as a wrong `ack_idx` or as an acknowledge that is missing.

// File: rtl/nia_pkg.sv
package nia_pkg;

  typedef enum logic [1:0] {
    SVC_NONE = 2'd0,
    SVC_MASK = 2'd1,
    SVC_SWI  = 2'd2,
    SVC_NMI  = 2'd3
  } svc_e;

  typedef struct packed {
    logic ie;
    logic isp;
    svc_e kind;
  } ctx_t;

  // May a maskable source with the given priority flag be taken now?
  function automatic logic maskable_ok(logic ie_f, logic isp_f, svc_e cur, logic low);
    return ie_f && (cur != SVC_NMI) && (isp_f || !low);
  endfunction

  // Non-maskable and software requests wait only for non-maskable service to end.
  function automatic logic unmaskable_ok(svc_e cur);
    return cur != SVC_NMI;
  endfunction

  // ISP value after a source of this kind/priority is taken.
  function automatic logic isp_after(svc_e kind, logic low);
    return (kind == SVC_MASK) ? low : 1'b1;
  endfunction

endpackage

// File: rtl/nia_pending.sv
module nia_pending #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_in,
  input  logic               nmi_in,
  input  logic               swi_in,
  input  logic [NUM_SRC-1:0] clr_mask,
  input  logic               clr_nmi,
  input  logic               clr_swi,
  output logic [NUM_SRC-1:0] live_mask,
  output logic               live_nmi,
  output logic               live_swi
);

  logic [NUM_SRC-1:0] pend_q;
  logic               nmi_q;
  logic               swi_q;

  // A request counts in the same cycle it arrives.
  assign live_mask = pend_q | req_in;
  assign live_nmi  = nmi_q | nmi_in;
  assign live_swi  = swi_q | swi_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      nmi_q  <= 1'b0;
      swi_q  <= 1'b0;
    end else begin
      pend_q <= live_mask & ~clr_mask;
      nmi_q  <= live_nmi & ~clr_nmi;
      swi_q  <= live_swi & ~clr_swi;
    end
  end

  // R12: a latched request only disappears through an acknowledge clear
  p_hold_pending_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_q && !clr_nmi) |=> nmi_q);

endmodule

// File: rtl/nia_arbiter.sv
module nia_arbiter
  import nia_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = $clog2(NUM_SRC + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] live_mask,
  input  logic [NUM_SRC-1:0] src_mask,
  input  logic [NUM_SRC-1:0] src_low,
  input  logic               live_nmi,
  input  logic               live_swi,
  input  logic               ie_f,
  input  logic               isp_f,
  input  svc_e               cur,
  output logic               gnt_valid,
  output svc_e               gnt_kind,
  output logic [IDX_W-1:0]   gnt_idx,
  output logic               gnt_low,
  output logic [NUM_SRC-1:0] gnt_onehot
);

  localparam logic [IDX_W-1:0] SWI_IDX = IDX_W'(NUM_SRC);
  localparam logic [IDX_W-1:0] NMI_IDX = IDX_W'(NUM_SRC + 1);

  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] elig_hi;
  logic [NUM_SRC-1:0] elig_lo;
  logic [NUM_SRC-1:0] pick_set;
  logic [NUM_SRC-1:0] first_hot;
  logic [IDX_W-1:0]   mask_idx;
  logic               nmi_win;
  logic               swi_win;
  logic               mask_win;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = live_mask[g] && !src_mask[g] &&
                     maskable_ok(ie_f, isp_f, cur, src_low[g]);
  end

  assign elig_hi  = elig & ~src_low;
  assign elig_lo  = elig & src_low;
  assign pick_set = (elig_hi != '0) ? elig_hi : elig_lo;
  assign first_hot = pick_set & (~pick_set + NUM_SRC'(1));

  always_comb begin
    mask_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pick_set[i]) mask_idx = IDX_W'(i);
    end
  end

  assign nmi_win  = live_nmi && unmaskable_ok(cur);
  assign swi_win  = !nmi_win && live_swi && unmaskable_ok(cur);
  assign mask_win = !nmi_win && !swi_win && (pick_set != '0);

  always_comb begin
    gnt_valid  = nmi_win || swi_win || mask_win;
    gnt_kind   = SVC_NONE;
    gnt_idx    = '0;
    gnt_low    = 1'b0;
    gnt_onehot = '0;
    if (nmi_win) begin
      gnt_kind = SVC_NMI;
      gnt_idx  = NMI_IDX;
    end else if (swi_win) begin
      gnt_kind = SVC_SWI;
      gnt_idx  = SWI_IDX;
    end else if (mask_win) begin
      gnt_kind   = SVC_MASK;
      gnt_idx    = mask_idx;
      gnt_low    = src_low[mask_idx[$clog2(NUM_SRC > 1 ? NUM_SRC : 2)-1:0]];
      gnt_onehot = first_hot;
    end
  end

  // R7: at most one maskable source is granted
  p_onehot_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_onehot));
  // R7: a low-priority grant is never made over an eligible high-priority source
  p_high_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_win && gnt_low) |-> (elig_hi == '0));
  // R6: a granted maskable source is unmasked
  p_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(gnt_onehot) |-> ((gnt_onehot & src_mask) == '0));

endmodule

// File: rtl/nia_ctx_stack.sv
module nia_ctx_stack
  import nia_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  ctx_t push_ctx,
  input  logic pop,
  output ctx_t top_ctx,
  output logic empty,
  output logic full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  ctx_t             frames [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign top_ctx = frames[PTR_W'(cnt_q - CNT_W'(1))];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (push && !full) begin
      frames[PTR_W'(cnt_q)] <= push_ctx;
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop && !empty) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R11: depth never exceeds the configured number of frames
  p_stack_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R11: the controller never pushes into a full stack
  p_no_push_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nia_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int STACK_DEPTH = 4,
  parameter int IDX_W       = $clog2(NUM_SRC + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_mask,
  input  logic [NUM_SRC-1:0] irq_low,
  input  logic               nmi_req,
  input  logic               swi_req,
  input  logic               ei,
  input  logic               di,
  input  logic               reti,
  input  logic               boundary,
  output logic               ack,
  output logic [IDX_W-1:0]   ack_idx,
  output logic               ie,
  output logic               isp
);

  logic               ie_q;
  logic               isp_q;
  svc_e               cur_q;
  logic               ack_q;
  logic [IDX_W-1:0]   ack_idx_q;
  logic               skip_q;

  logic [NUM_SRC-1:0] live_mask;
  logic               live_nmi;
  logic               live_swi;
  logic               gnt_valid;
  svc_e               gnt_kind;
  logic [IDX_W-1:0]   gnt_idx;
  logic               gnt_low;
  logic [NUM_SRC-1:0] gnt_onehot;

  ctx_t               stk_top;
  logic               stk_empty;
  logic               stk_full;

  // Named internal events
  logic               blocked;
  logic               take;
  logic               pop_ev;
  logic [NUM_SRC-1:0] clr_mask;
  logic               clr_nmi;
  logic               clr_swi;
  ctx_t               save_ctx;
  logic               top_ie;

  assign blocked  = reti || skip_q || stk_full;
  assign take     = boundary && gnt_valid && !blocked;
  assign pop_ev   = reti && !stk_empty;
  assign clr_mask = take ? gnt_onehot : '0;
  assign clr_nmi  = take && (gnt_kind == SVC_NMI);
  assign clr_swi  = take && (gnt_kind == SVC_SWI);
  assign save_ctx = '{ie: ie_q, isp: isp_q, kind: cur_q};
  assign top_ie   = stk_top.ie;

  nia_pending #(.NUM_SRC(NUM_SRC)) u_pending (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_in    (irq_req),
    .nmi_in    (nmi_req),
    .swi_in    (swi_req),
    .clr_mask  (clr_mask),
    .clr_nmi   (clr_nmi),
    .clr_swi   (clr_swi),
    .live_mask (live_mask),
    .live_nmi  (live_nmi),
    .live_swi  (live_swi)
  );

  nia_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arbiter (
    .clk        (clk),
    .rst_n      (rst_n),
    .live_mask  (live_mask),
    .src_mask   (irq_mask),
    .src_low    (irq_low),
    .live_nmi   (live_nmi),
    .live_swi   (live_swi),
    .ie_f       (ie_q),
    .isp_f      (isp_q),
    .cur        (cur_q),
    .gnt_valid  (gnt_valid),
    .gnt_kind   (gnt_kind),
    .gnt_idx    (gnt_idx),
    .gnt_low    (gnt_low),
    .gnt_onehot (gnt_onehot)
  );

  nia_ctx_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (take),
    .push_ctx (save_ctx),
    .pop      (pop_ev),
    .top_ctx  (stk_top),
    .empty    (stk_empty),
    .full     (stk_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q      <= 1'b0;
      isp_q     <= 1'b1;
      cur_q     <= SVC_NONE;
      ack_q     <= 1'b0;
      ack_idx_q <= '0;
      skip_q    <= 1'b0;
    end else begin
      ack_q <= take;
      if (take) ack_idx_q <= gnt_idx;

      if (reti && !boundary) skip_q <= 1'b1;
      else if (boundary)     skip_q <= 1'b0;

      if (take)        ie_q <= 1'b0;
      else if (pop_ev) ie_q <= stk_top.ie;
      else if (ei)     ie_q <= 1'b1;
      else if (di)     ie_q <= 1'b0;

      if (take) begin
        isp_q <= isp_after(gnt_kind, gnt_low);
        cur_q <= gnt_kind;
      end else if (pop_ev) begin
        isp_q <= stk_top.isp;
        cur_q <= stk_top.kind;
      end
    end
  end

  assign ack     = ack_q;
  assign ack_idx = ack_idx_q;
  assign ie      = ie_q;
  assign isp     = isp_q;

  // R2: an acknowledge always follows a boundary
  p_ack_after_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(boundary));
  // R3: IE is low whenever the acknowledge pulse is seen
  p_ack_clears_ie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !ie);
  // R4: non-maskable service refuses everything
  p_nmi_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && cur_q == SVC_NMI) |=> !ack);
  // R6: with ISP=0 no low-priority maskable source is taken
  p_low_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && gnt_kind == SVC_MASK && !isp_q) |-> !gnt_low);
  // R9: a return restores the saved IE
  p_restore_ie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |=> (ie == $past(top_ie)));
  // R10: the boundary of a return never acknowledges
  p_reti_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && reti) |=> !ack);
  // R11: a full stack refuses all requests
  p_full_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && stk_full) |=> !ack);

endmodule

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;

  localparam int N   = 4;
  localparam int D   = 4;
  localparam int IW  = $clog2(N + 2);
  localparam int SWI = N;
  localparam int NMI = N + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0, irq_mask = '0, irq_low = '0;
  logic          nmi_req = 1'b0, swi_req = 1'b0, ei = 1'b0, di = 1'b0;
  logic          reti = 1'b0, boundary = 1'b0;
  logic          ack;
  logic [IW-1:0] ack_idx;
  logic          ie, isp;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  nest_irq_ctrl #(.NUM_SRC(N), .STACK_DEPTH(D)) i_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_mask(irq_mask),
    .irq_low(irq_low), .nmi_req(nmi_req), .swi_req(swi_req), .ei(ei),
    .di(di), .reti(reti), .boundary(boundary), .ack(ack),
    .ack_idx(ack_idx), .ie(ie), .isp(isp)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock; inputs were set at a negedge, outputs read at the next negedge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    irq_req = '0; nmi_req = 0; swi_req = 0; ei = 0; di = 0;
    reti = 0; boundary = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; irq_mask = '0; irq_low = '0;
    step(); step();
    rst_n = 1;
  endtask

  // Bench view of arbitration: scan high level, then low level, lowest index.
  function automatic int exp_winner(logic [N-1:0] r, logic [N-1:0] m, logic [N-1:0] p);
    for (int lvl = 0; lvl < 2; lvl++)
      for (int i = 0; i < N; i++)
        if (r[i] && !m[i] && (p[i] == lvl[0])) return i;
    return -1;
  endfunction

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 ie", ie, 0);
    check("R1 isp", isp, 1);
    check("R1 ack", ack, 0);

    // R1/R6: IE=0 after reset refuses a maskable request; R12 keeps it
    irq_req = 4'b0001; boundary = 1; step();
    check("R6 ie0 refuse", ack, 0);
    ei = 1; step();
    check("R3 ei sets", ie, 1);
    di = 1; step();
    check("R3 di clears", ie, 0);
    ei = 1; step();
    // R2: no decision without boundary
    step();
    check("R2 no boundary", ack, 0);
    boundary = 1; step();
    check("R12 held then taken", ack, 1);
    check("R2 idx", ack_idx, 0);
    step();
    check("R2 single pulse", ack, 0);
    // R9: empty-stack return after popping
    reti = 1; boundary = 1; step();
    check("R9 ie restored", ie, 1);
    reti = 1; step();
    check("R9 empty reti ie", ie, 1);
    check("R9 empty reti isp", isp, 1);

    // R3: acknowledge beats a coincident ei
    do_reset();
    ei = 1; step();
    irq_req = 4'b0100; ei = 1; boundary = 1; step();
    check("R3 ack vs ei ack", ack, 1);
    check("R3 ack vs ei ie", ie, 0);

    // R12: masked pending survives, taken after unmask
    do_reset();
    ei = 1; step();
    irq_mask = 4'b1000; irq_req = 4'b1000; boundary = 1; step();
    check("R12 masked no ack", ack, 0);
    irq_mask = '0; boundary = 1; step();
    check("R12 unmasked ack", ack, 1);
    check("R12 unmasked idx", ack_idx, 3);

    // R10: return without boundary blocks the next boundary only
    reti = 1; step();
    irq_req = 4'b0010; boundary = 1; step();
    check("R10 skip after reti", ack, 0);
    boundary = 1; step();
    check("R10 taken after one instr", ack, 1);
    check("R10 idx", ack_idx, 1);

    // R5: priority order NMI > SWI > maskable
    do_reset();
    ei = 1; step();
    nmi_req = 1; swi_req = 1; irq_req = 4'b0001; boundary = 1; step();
    check("R5 nmi first", ack_idx, NMI);
    reti = 1; boundary = 1; step();
    boundary = 1; step();
    check("R5 swi second", ack_idx, SWI);
    check("R8 isp after swi", isp, 1);

    // R11: fill the stack with same-priority nesting
    do_reset();
    for (int k = N - 1; k >= 0; k--) begin
      ei = 1; step();
      irq_req[k] = 1'b1; boundary = 1; step();
      check("R11 nest fill", ack_idx, k);
    end
    ei = 1; step();
    nmi_req = 1; boundary = 1; step();
    check("R11 full refuses nmi", ack, 0);
    reti = 1; boundary = 1; step();
    check("R10 reti boundary quiet", ack, 0);
    boundary = 1; step();
    check("R11 nmi after pop", ack_idx, NMI);
    check("R11 nmi ack", ack, 1);

    // R4/R5/R6/R8/R9/R10: in-service context x IE x request type
    for (int ctx = 0; ctx < 5; ctx++) begin
      for (int ion = 0; ion < 2; ion++) begin
        for (int rq = 0; rq < 3; rq++) begin
          int acc, want;
          do_reset();
          irq_low[1] = (ctx == 2);
          irq_low[2] = (rq == 2);
          if (ctx != 0) begin
            ei = 1; step();
            if (ctx == 1 || ctx == 2) irq_req[1] = 1'b1;
            if (ctx == 3) swi_req = 1;
            if (ctx == 4) nmi_req = 1;
            boundary = 1; step();
            check("R5 context ack", ack, 1);
            check("R2 context idx", ack_idx, (ctx <= 2) ? 1 : (ctx == 3 ? SWI : NMI));
            check("R8 context isp", isp, (ctx == 1) ? 0 : 1);
          end
          if (ion == 1) begin ei = 1; step(); end
          if (rq == 0) nmi_req = 1; else irq_req[2] = 1'b1;
          boundary = 1; step();
          acc = (ctx == 4) ? 0 : (rq == 0) ? 1 : ((ion == 1 && !(rq == 2 && ctx == 1)) ? 1 : 0);
          want = (rq == 0) ? NMI : 2;
          check("R4 R6 nest decision", ack, acc);
          if (acc == 1) check("R2 nest idx", ack_idx, want);
          if (acc == 0 && ctx != 0) begin
            reti = 1; boundary = 1; step();
            check("R10 return quiet", ack, 0);
            check("R9 ie back", ie, 1);
            check("R9 isp back", isp, 1);
            boundary = 1; step();
            check("R10 held taken", ack, 1);
            check("R10 held idx", ack_idx, want);
          end
          if (acc == 0 && ctx == 0) begin
            ei = 1; step();
            boundary = 1; step();
            check("R12 held idle", ack_idx, want);
          end
        end
      end
    end

    // R7/R8: sweep of request, mask and priority patterns from idle with IE=1
    for (int r = 0; r < 16; r++)
      for (int p = 0; p < 16; p++)
        for (int m = 0; m < 16; m++) begin
          int w;
          do_reset();
          ei = 1; step();
          irq_low = p[N-1:0]; irq_mask = m[N-1:0];
          irq_req = r[N-1:0]; boundary = 1; step();
          w = exp_winner(r[N-1:0], m[N-1:0], p[N-1:0]);
          check("R7 ack", ack, (w >= 0) ? 1 : 0);
          if (w >= 0) begin
            check("R7 winner", ack_idx, w);
            check("R8 isp", isp, p[w]);
          end
        end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule